// File: doc/BRIEF.md
# Two-Level Page Walk Address Translator

This block converts 32-bit device virtual addresses into 39-bit physical addresses. A client presents a virtual address on a valid/ready request port. The block first searches a small fully associative translation cache. On a hit it answers in the cycle after the request is accepted. On a miss it reads two 32-bit table entries from memory and answers with the result. The first read comes from a first-level table selected by the top ten address bits. The second comes from a second-level table selected by the next ten bits. The low 12 bits are the byte offset inside a 4 KiB page and pass through unchanged.

Every entry is taken as a 27-bit page frame number. There is no "not present" encoding: unmapped slots point at placeholder tables or pages, so every walk ends with an address. A register port sets the frame number of the first-level table and can flush the whole cache. Only one walk runs at a time, and new requests are held off until it finishes. If a flush arrives while a walk is in flight, the walk still answers its client, but its result is not cached.

Top module: `xlat_unit`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_req is 0.
- R2: On a cache miss the block issues exactly two one-cycle reads. The first is at byte address base_frame*4096 + vaddr[31:22]*4. The second is at F1*4096 + vaddr[21:12]*4, where F1 is bits 26:0 of the first read's data. Data bits 31:27 are ignored.
- R3: The response address is F2*4096 + vaddr[11:0], where F2 is bits 26:0 of the second read's data.
- R4: When vaddr[31:12] matches a cached entry, rsp_valid is 1 in the cycle after acceptance and no memory read is issued.
- R5: While a request is accepted but not yet answered, req_ready stays 0. Only one walk is ever in progress.
- R6: Any number of wait cycles between mem_req and mem_rsp_valid is tolerated. A miss answers 2*W+6 cycles after acceptance, where W is the number of idle cycles the memory inserts before each reply.
- R7: A write to configuration offset 0x4304 loads cfg_wdata[26:0] as the first-level table frame. Bits 31:27 are ignored.
- R8: A write of value 1 to offset 0x0300 invalidates every cached entry. Any other value written there, and any write to another offset, leaves the cache untouched.
- R9: A flush that arrives during a walk does not stop that walk from answering correctly, but its result is not cached. The next request to the same page walks again.
- R10: The cache holds 8 entries and fills them in round-robin order. The ninth distinct page installed after a flush evicts the first one, and the other seven stay cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle strobe: rsp_paddr is valid |
| rsp_paddr | output | 39 | Translated physical address |
| mem_req | output | 1 | One-cycle table-entry read strobe |
| mem_addr | output | 39 | Byte address of the table entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Table entry word |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 16 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |

## Verification
Translations are tried with a fresh page (a full walk), the same page again at another offset (a cached answer), and a page at the top of the address space under a slow memory. The fresh page confirms the entry addresses. The repeated page separates the hit path from the walk. The slow memory shows that latency only stretches the answer. Flush writes with the correct value, a wrong value and a wrong offset show that only the exact command empties the cache, and a flush placed mid-walk shows that the answer survives but is not installed. Nine distinct pages after a flush show which entry the round-robin pointer evicts and that the other seven remain.

// File: rtl/xlat_pkg.sv
// Shared widths, register offsets and controller states for the address
// translator. Assumes 4 KiB pages and 32-bit table entries.
package xlat_pkg;
    localparam int VA_W    = 32;
    localparam int PFN_W   = 27;
    localparam int OFF_W   = 12;
    localparam int PA_W    = PFN_W + OFF_W;
    localparam int IDX_W   = 10;
    localparam int TAG_W   = VA_W - OFF_W;
    localparam int DATA_W  = 32;
    localparam int CFG_AW  = 16;

    localparam logic [CFG_AW-1:0] CFG_FLUSH_OFS = 16'h0300;
    localparam logic [CFG_AW-1:0] CFG_BASE_OFS  = 16'h4304;
    localparam logic [DATA_W-1:0] FLUSH_CMD     = 32'd1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_RESP
    } xlat_state_e;
endpackage

// File: rtl/xlat_cfg_regs.sv
// Configuration decode: holds the first-level table frame and raises a
// one-cycle flush when the exact flush command is written.
// Assumes the write strobe lasts one cycle per write.
module xlat_cfg_regs
    import xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [PFN_W-1:0]  base_pfn,
    output logic              flush
);
    logic unused_cfg_hi;
    assign unused_cfg_hi = ^cfg_wdata[DATA_W-1:PFN_W];

    // Flush strobe: only the exact command value at the flush offset.
    assign flush = cfg_we && (cfg_addr == CFG_FLUSH_OFS) && (cfg_wdata == FLUSH_CMD);

    // Base frame register: loaded from the low frame bits of the write data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_pfn <= '0;
        else if (cfg_we && cfg_addr == CFG_BASE_OFS)
            base_pfn <= cfg_wdata[PFN_W-1:0];
    end
endmodule

// File: rtl/xlat_tlb.sv
// Fully associative translation cache keyed by the virtual page number.
// Lookup is combinational; install goes to the round-robin victim.
// Assumes the controller never installs a tag that is already present.
module xlat_tlb #(
    parameter int N_ENTRIES = 8,
    parameter int TAG_BITS  = 20,
    parameter int PFN_BITS  = 27
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TAG_BITS-1:0] lk_tag,
    output logic                lk_hit,
    output logic [PFN_BITS-1:0] lk_pfn,
    input  logic                ins_en,
    input  logic [PFN_BITS-1:0] ins_pfn,
    input  logic                flush
);
    localparam int PTR_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(N_ENTRIES - 1);

    logic [N_ENTRIES-1:0] valid_q;
    logic [N_ENTRIES-1:0] hit_vec;
    logic [TAG_BITS-1:0]  tag_q [N_ENTRIES];
    logic [PFN_BITS-1:0]  pfn_q [N_ENTRIES];
    logic [PTR_W-1:0]     victim_q;

    // Per-entry tag comparators.
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid_q[g] && (tag_q[g] == lk_tag);
    end

    // Hit flag and OR-mux of the matching frame.
    always_comb begin
        lk_hit = |hit_vec;
        lk_pfn = '0;
        for (int i = 0; i < N_ENTRIES; i++)
            if (hit_vec[i]) lk_pfn = lk_pfn | pfn_q[i];
    end

    // Valid bits and victim pointer; flush overrides an install.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= '0;
            victim_q <= '0;
        end else if (flush) begin
            valid_q  <= '0;
        end else if (ins_en) begin
            valid_q[victim_q] <= 1'b1;
            victim_q <= (victim_q == LAST) ? '0 : victim_q + 1'b1;
        end
    end

    // Entry payload storage, written on install.
    always_ff @(posedge clk) begin
        if (ins_en && !flush) begin
            tag_q[victim_q] <= lk_tag;
            pfn_q[victim_q] <= ins_pfn;
        end
    end
endmodule

// File: rtl/xlat_walk_ctrl.sv
// Request handshake, cache lookup sequencing and the two-read table walk.
// Assumes one outstanding memory read; every read returns exactly once.
module xlat_walk_ctrl
    import xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic [PFN_W-1:0]  base_pfn,
    input  logic              flush,
    output logic [TAG_W-1:0]  tlb_tag,
    input  logic              tlb_hit,
    input  logic [PFN_W-1:0]  tlb_pfn,
    output logic              ins_en,
    output logic [PFN_W-1:0]  ins_pfn
);
    xlat_state_e      state_q, state_d;
    logic [VA_W-1:0]  vaddr_q;
    logic [PFN_W-1:0] pfn_q;
    logic             spoil_q;
    logic             accept;
    logic             unused_data_hi;

    assign unused_data_hi = ^mem_rsp_data[DATA_W-1:PFN_W];

    assign req_ready = (state_q == ST_IDLE) || (state_q == ST_LOOK && tlb_hit);
    assign accept    = req_valid && req_ready;
    assign tlb_tag   = vaddr_q[VA_W-1:OFF_W];

    // Response: cached frame on a hit, walked frame at the end of a walk.
    assign rsp_valid = (state_q == ST_LOOK && tlb_hit) || (state_q == ST_RESP);
    assign rsp_paddr = (state_q == ST_RESP) ? {pfn_q, vaddr_q[OFF_W-1:0]}
                                            : {tlb_pfn, vaddr_q[OFF_W-1:0]};

    // Entry address: table frame followed by the 10-bit index and a zero byte lane.
    assign mem_req  = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
    assign mem_addr = (state_q == ST_L1_REQ)
                    ? {base_pfn, vaddr_q[VA_W-1 -: IDX_W], 2'b00}
                    : {pfn_q, vaddr_q[OFF_W+IDX_W-1 -: IDX_W], 2'b00};

    // Install a walked result unless a flush touched this walk.
    assign ins_en  = (state_q == ST_RESP) && !spoil_q && !flush;
    assign ins_pfn = pfn_q;

    // Next-state logic of the lookup and walk sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_LOOK;
            ST_LOOK:    if (!tlb_hit) state_d = ST_L1_REQ;
                        else if (!accept) state_d = ST_IDLE;
            ST_L1_REQ:  state_d = ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rsp_valid) state_d = ST_L2_REQ;
            ST_L2_REQ:  state_d = ST_L2_WAIT;
            ST_L2_WAIT: if (mem_rsp_valid) state_d = ST_RESP;
            ST_RESP:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State, latched address, walked frame and spoil flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vaddr_q <= '0;
            pfn_q   <= '0;
            spoil_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) vaddr_q <= req_vaddr;
            if (mem_rsp_valid && (state_q == ST_L1_WAIT || state_q == ST_L2_WAIT))
                pfn_q <= mem_rsp_data[PFN_W-1:0];
            if (accept)
                spoil_q <= 1'b0;
            else if (flush && state_q != ST_IDLE)
                spoil_q <= 1'b1;
        end
    end
endmodule

// File: rtl/xlat_unit.sv
// Top of the two-level address translator: configuration decode, cache and
// walk controller. Assumes memory replies in order, one word per read.
module xlat_unit
    import xlat_pkg::*;
#(
    parameter int TLB_ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata
);
    logic [PFN_W-1:0] base_pfn;
    logic             flush;
    logic [TAG_W-1:0] tlb_tag;
    logic             tlb_hit;
    logic [PFN_W-1:0] tlb_pfn;
    logic             ins_en;
    logic [PFN_W-1:0] ins_pfn;

    xlat_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .base_pfn(base_pfn), .flush(flush)
    );

    xlat_tlb #(.N_ENTRIES(TLB_ENTRIES), .TAG_BITS(TAG_W), .PFN_BITS(PFN_W)) u_tlb (
        .clk(clk), .rst_n(rst_n), .lk_tag(tlb_tag), .lk_hit(tlb_hit),
        .lk_pfn(tlb_pfn), .ins_en(ins_en), .ins_pfn(ins_pfn), .flush(flush)
    );

    xlat_walk_ctrl u_walk (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .base_pfn(base_pfn), .flush(flush),
        .tlb_tag(tlb_tag), .tlb_hit(tlb_hit), .tlb_pfn(tlb_pfn),
        .ins_en(ins_en), .ins_pfn(ins_pfn)
    );
endmodule

// File: rtl/xlat_unit_checker.sv
// Protocol checker for the translator, bound to every xlat_unit instance.
// Tracks the pending request and the outstanding memory read.
module xlat_unit_checker
    import xlat_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic            rsp_valid,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            mem_req,
    input logic            mem_rsp_valid
);
    logic             busy_q;
    logic             rd_out_q;
    logic [OFF_W-1:0] off_q;

    // Pending-request, pending-read and offset trackers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            rd_out_q <= 1'b0;
            off_q    <= '0;
        end else begin
            if (req_valid && req_ready) begin
                busy_q <= 1'b1;
                off_q  <= req_vaddr[OFF_W-1:0];
            end else if (rsp_valid) begin
                busy_q <= 1'b0;
            end
            if (mem_req) rd_out_q <= 1'b1;
            else if (mem_rsp_valid) rd_out_q <= 1'b0;
        end
    end

    assert_rsp_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy_q);
    assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_paddr[OFF_W-1:0] == off_q);
    assert_stall_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !rsp_valid) |-> !req_ready);
    assert_read_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    assert_one_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !rd_out_q);
endmodule

bind xlat_unit xlat_unit_checker u_xlat_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .mem_req(mem_req), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/xlat_unit_bench.sv
// Directed bench for xlat_unit with a behavioural table memory.
module xlat_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic        rsp_valid;
    logic [38:0] rsp_paddr;
    logic        mem_req;
    logic [38:0] mem_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        cfg_we;
    logic [15:0] cfg_addr;
    logic [31:0] cfg_wdata;

    int          checks = 0;
    int          failures = 0;
    int          rd_cnt = 0;
    int          mem_lat = 0;
    logic [38:0] prev_addr = '0;
    logic [38:0] last_addr = '0;
    logic [26:0] cur_base = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_unit u_xlat_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata)
    );

    // Table contents: first-level slots point at per-index tables.
    function automatic logic [26:0] l1_frame(input logic [9:0] idx);
        return 27'h100 + 27'(idx);
    endfunction
    function automatic logic [26:0] l2_frame(input logic [26:0] tbl, input logic [9:0] idx);
        return {tbl[16:0], idx};
    endfunction
    function automatic logic [38:0] expect_pa(input logic [31:0] va);
        logic [26:0] f2;
        f2 = l2_frame(l1_frame(va[31:22]), va[21:12]);
        return (39'(f2) << 12) + 39'(va[11:0]);
    endfunction

    // Memory model: answers each read after mem_lat idle cycles, junk in bits 31:27.
    initial begin
        logic [38:0] a;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req) begin
                rd_cnt++;
                prev_addr = last_addr;
                last_addr = mem_addr;
                a = mem_addr;
                repeat (mem_lat) @(negedge clk);
                @(negedge clk);
                mem_rsp_valid = 1'b1;
                if (a[38:12] == cur_base)
                    mem_rsp_data = {5'h15, l1_frame(a[11:2])};
                else
                    mem_rsp_data = {5'h15, l2_frame(a[38:12], a[11:2])};
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One translation; optionally flushes two cycles after acceptance.
    task automatic xlat(input logic [31:0] va, input bit flush_mid,
                        output logic [38:0] pa, output int lat,
                        output int reads, output bit stall_ok);
        int r0;
        r0 = rd_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; stall_ok = 1'b1;
        while (!rsp_valid && lat < 5000) begin
            if (req_ready) stall_ok = 1'b0;
            if (flush_mid && lat == 2) begin
                cfg_we = 1'b1; cfg_addr = 16'h0300; cfg_wdata = 32'd1;
            end else begin
                cfg_we = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        cfg_we = 1'b0;
        pa = rsp_paddr;
        reads = rd_cnt - r0;
    endtask

    task automatic t_reset;
        check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
        check(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
    endtask

    task automatic t_miss;
        logic [38:0] pa; int lat, rd; bit st;
        logic [31:0] va;
        va = 32'h1234_5ABC;
        xlat(va, 1'b0, pa, lat, rd, st);
        check(rd == 2, "R2", "reads on miss", rd, 2);
        check(prev_addr == (39'(cur_base) << 12) + 39'(va[31:22]) * 4, "R2",
              "first-level entry address", prev_addr, (39'(cur_base) << 12) + 39'(va[31:22]) * 4);
        check(last_addr == (39'(l1_frame(va[31:22])) << 12) + 39'(va[21:12]) * 4, "R2",
              "second-level entry address", last_addr,
              (39'(l1_frame(va[31:22])) << 12) + 39'(va[21:12]) * 4);
        check(pa == expect_pa(va), "R3", "walked physical address", pa, expect_pa(va));
        check(lat == 6, "R6", "miss latency zero wait", lat, 6);
        check(st, "R5", "ready low during walk", st, 1);
    endtask

    task automatic t_hit;
        logic [38:0] pa; int lat, rd; bit st;
        xlat(32'h1234_50F0, 1'b0, pa, lat, rd, st);
        check(pa == expect_pa(32'h1234_50F0), "R4", "hit address", pa, expect_pa(32'h1234_50F0));
        check(lat == 1, "R4", "hit latency", lat, 1);
        check(rd == 0, "R4", "reads on hit", rd, 0);
    endtask

    task automatic t_slow_mem;
        logic [38:0] pa; int lat, rd; bit st;
        mem_lat = 5;
        xlat(32'hFFC0_3001, 1'b0, pa, lat, rd, st);
        mem_lat = 0;
        check(pa == expect_pa(32'hFFC0_3001), "R6", "slow memory address", pa, expect_pa(32'hFFC0_3001));
        check(lat == 16, "R6", "slow memory latency", lat, 16);
        check(rd == 2, "R6", "slow memory reads", rd, 2);
        check(st, "R5", "ready low during slow walk", st, 1);
    endtask

    task automatic t_base;
        logic [38:0] pa; int lat, rd; bit st;
        cur_base = 27'h300_0123;
        cfg_write(16'h4304, {5'h1F, cur_base});
        cfg_write(16'h0300, 32'd1);
        xlat(32'h0040_1008, 1'b0, pa, lat, rd, st);
        check(prev_addr == (39'(cur_base) << 12) + 39'd4, "R7", "new base used", prev_addr,
              (39'(cur_base) << 12) + 39'd4);
        check(pa == expect_pa(32'h0040_1008), "R7", "address under new base", pa,
              expect_pa(32'h0040_1008));
    endtask

    task automatic t_flush_decode;
        logic [38:0] pa; int lat, rd; bit st;
        xlat(32'h0040_1000, 1'b0, pa, lat, rd, st);
        check(rd == 0, "R8", "cached before flush tests", rd, 0);
        cfg_write(16'h0300, 32'd2);
        xlat(32'h0040_1000, 1'b0, pa, lat, rd, st);
        check(rd == 0 && lat == 1, "R8", "wrong value no flush", rd, 0);
        cfg_write(16'h0304, 32'd1);
        xlat(32'h0040_1000, 1'b0, pa, lat, rd, st);
        check(rd == 0 && lat == 1, "R8", "wrong offset no flush", rd, 0);
        cfg_write(16'h0300, 32'd1);
        xlat(32'h0040_1000, 1'b0, pa, lat, rd, st);
        check(rd == 2, "R8", "exact command flushes", rd, 2);
    endtask

    task automatic t_flush_mid;
        logic [38:0] pa; int lat, rd; bit st;
        mem_lat = 4;
        xlat(32'h8765_4321, 1'b1, pa, lat, rd, st);
        mem_lat = 0;
        check(pa == expect_pa(32'h8765_4321), "R9", "walk answers after flush", pa,
              expect_pa(32'h8765_4321));
        xlat(32'h8765_4000, 1'b0, pa, lat, rd, st);
        check(rd == 2, "R9", "spoiled walk not cached", rd, 2);
        xlat(32'h8765_4FFF, 1'b0, pa, lat, rd, st);
        check(rd == 0 && pa == expect_pa(32'h8765_4FFF), "R9", "later walk cached", rd, 0);
    endtask

    task automatic t_round_robin;
        logic [38:0] pa; int lat, rd; bit st;
        int hits;
        cfg_write(16'h0300, 32'd1);
        for (int i = 0; i < 8; i++) xlat(32'(i) << 14, 1'b0, pa, lat, rd, st);
        hits = 0;
        for (int i = 0; i < 8; i++) begin
            xlat(32'(i) << 14, 1'b0, pa, lat, rd, st);
            if (rd == 0) hits++;
        end
        check(hits == 8, "R10", "eight pages cached", hits, 8);
        xlat(32'd8 << 14, 1'b0, pa, lat, rd, st);
        check(rd == 2, "R10", "ninth page walks", rd, 2);
        xlat(32'd1 << 14, 1'b0, pa, lat, rd, st);
        check(rd == 0, "R10", "second page kept", rd, 0);
        xlat(32'd0, 1'b0, pa, lat, rd, st);
        check(rd == 2, "R10", "first page evicted", rd, 2);
        check(pa == expect_pa(32'd0), "R10", "evicted page re-walked", pa, expect_pa(32'd0));
        xlat(32'd2 << 14, 1'b0, pa, lat, rd, st);
        check(rd == 0, "R10", "third page kept", rd, 0);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        cur_base = 27'h0AB_CDE;
        cfg_write(16'h4304, {5'h0, cur_base});
        t_miss();
        t_hit();
        t_slow_mem();
        t_base();
        t_flush_decode();
        t_flush_mid();
        t_round_robin();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule